// File: doc/BRIEF.md
# LUT-Based Memory-Polynomial Predistortion Actuator

This block predistorts a continuous stream of complex baseband samples ahead of a power amplifier. It accepts one sample per clock and produces one corrected sample per clock. There is no handshake, and the delay through the block is fixed. Each output is the sum of a small set of product terms. In each term, a complex gain is looked up by the quantized envelope of one past sample (tap `i`). That gain then multiplies another past sample (tap `j`). Folding the polynomial coefficient and the envelope power into the table turns every term into one table read and one complex multiply.

A single write port loads the tables, picks the table bank that every term reads from, and programs each term's enable and its `i`/`j` taps. Tables for the other banks can be loaded while one bank is in use, so a new model can be prepared and then switched in with one write. Coefficient estimation happens elsewhere. This block only applies the model.

Top module: `gmp_lut_predist`

## Requirements
- R1: While `rst_n` is low and on the first output after it rises, `out_i` and `out_q` are 0. Reset also clears the bank select to 0 and disables every term.
- R2: With a single enabled term using taps i=0 and j=0, and every entry of its table equal to gain 1.0 (I=16384, Q=0), the output equals the input.
- R3: The output for the sample captured at clock edge k appears after edge k+3, and there is no other latency.
- R4: Tap `j` selects the sample multiplied, x(n-j). Tap `i` independently selects the sample whose envelope addresses the table, x(n-i). Both taps range from 0 to 7 over one shared history. A run of 11 zero inputs makes the output 0.
- R5: The table index is min(255, (max(|I|,|Q|) + floor(min(|I|,|Q|)/2)) >> 7). A component of -32768 is treated as magnitude 32767.
- R6: A term whose enable bit is 0 adds nothing to the output, whatever its table holds.
- R7: Every term reads its table in the one selected bank (0 to 3). A bank change alters the gains of every term together.
- R8: All enabled terms are summed at full precision. The sum is rounded by adding 8192 and shifting arithmetically right by 14, then saturated to [-32768, 32767].
- R9: Table entries are complex gains in Q2.14 (bits 31:16 I, bits 15:0 Q). Each term contributes I = gI·xI − gQ·xQ and Q = gI·xQ + gQ·xI.
- R10: A configuration write presented in the same cycle as a sample already applies to that sample. Nothing else changes the configuration.
- R11: When `cfg_addr` MSB is 1, the write goes to a table entry addressed as {1, bank[1:0], term, index[7:0]}. When the MSB is 0, the low field selects a register. Field value 0 is the bank select, data bits 1:0. Field value t+1 is the control for term t: bit 0 enable, bits 3:1 tap i, bits 6:4 tap j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_i | input | DW | Input sample, in-phase |
| in_q | input | DW | Input sample, quadrature |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1+BW+TW+IDXW | Configuration address (table entry or register) |
| cfg_wdata | input | 2*CW | Configuration write data |
| out_i | output | DW | Predistorted sample, in-phase |
| out_q | output | DW | Predistorted sample, quadrature |

## Verification
The bench builds the block with three terms, which makes the term field two bits wide with one code unused. Three terms also allow one term to stay disabled while holding large gains, while the other two overlap with different taps. The bench keeps the default 16-bit samples, 8-bit index, four banks and taps up to 7. That reaches envelope saturation at index 255, output saturation when three gains near 2.0 are summed, and switching across all four banks.

// File: rtl/gmp_lut_predist.sv
module gmp_lut_predist #(
  parameter  int NTERMS = 2,
  parameter  int DW     = 16,
  parameter  int CW     = 16,
  parameter  int FRAC   = 14,
  parameter  int NBANKS = 4,
  parameter  int IDXW   = 8,
  parameter  int TAPS   = 8,
  localparam int TW     = (NTERMS > 1) ? $clog2(NTERMS) : 1,
  localparam int BW     = (NBANKS > 1) ? $clog2(NBANKS) : 1,
  localparam int CAW    = 1 + BW + TW + IDXW
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 cfg_we,
  input  logic [CAW-1:0]       cfg_addr,
  input  logic [2*CW-1:0]      cfg_wdata,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int DLW = $clog2(TAPS);
  localparam int TD  = 1 << IDXW;
  localparam int TBL = NBANKS * NTERMS * TD;
  localparam int LAW = $clog2(TBL);
  localparam int SH  = DW - 1 - IDXW;
  localparam int PW  = DW + CW;
  localparam int AW  = PW + TW + 3;
  localparam logic signed [AW-1:0] OMAX = (AW'(1) <<< (DW - 1)) - 1;
  localparam logic signed [AW-1:0] OMIN = -OMAX - 1;

  function automatic logic [IDXW-1:0] env_idx(input logic signed [DW-1:0] a, input logic signed [DW-1:0] b);
    logic [DW-1:0] ua, ub, hi, lo, m;
    ua = a;
    ub = b;
    if (a[DW-1]) ua = ~ua + 1'b1;
    if (b[DW-1]) ub = ~ub + 1'b1;
    if (ua[DW-1]) ua = {1'b0, {(DW-1){1'b1}}};
    if (ub[DW-1]) ub = {1'b0, {(DW-1){1'b1}}};
    hi = (ua > ub) ? ua : ub;
    lo = (ua > ub) ? ub : ua;
    m  = hi + (lo >> 1);
    return (|m[DW-1:SH+IDXW]) ? {IDXW{1'b1}} : m[SH+IDXW-1:SH];
  endfunction

  function automatic logic signed [DW-1:0] clip(input logic signed [AW-1:0] v);
    if (v > OMAX) return OMAX[DW-1:0];
    if (v < OMIN) return OMIN[DW-1:0];
    return v[DW-1:0];
  endfunction

  // sample history and envelope history
  logic signed [DW-1:0] hx_i [TAPS];
  logic signed [DW-1:0] hx_q [TAPS];
  logic [IDXW-1:0]      hmag [TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        hx_i[k] <= '0;
        hx_q[k] <= '0;
        hmag[k] <= '0;
      end
    end else begin
      hx_i[0] <= in_i;
      hx_q[0] <= in_q;
      hmag[0] <= env_idx(in_i, in_q);
      for (int k = 1; k < TAPS; k++) begin
        hx_i[k] <= hx_i[k-1];
        hx_q[k] <= hx_q[k-1];
        hmag[k] <= hmag[k-1];
      end
    end
  end

  // configuration
  wire              tbl_sel = cfg_addr[CAW-1];
  wire [CAW-2:0]    reg_sel = cfg_addr[CAW-2:0];
  wire [BW-1:0]     w_bank  = cfg_addr[CAW-2 -: BW];
  wire [TW-1:0]     w_term  = cfg_addr[IDXW+TW-1 -: TW];
  wire [IDXW-1:0]   w_idx   = cfg_addr[IDXW-1:0];
  logic             term_ok;

  generate
    if ((1 << TW) == NTERMS) begin : g_full
      assign term_ok = 1'b1;
    end else begin : g_part
      assign term_ok = (w_term < TW'(NTERMS));
    end
  endgenerate

  logic [BW-1:0]     bank_q;
  logic [NTERMS-1:0] ten;
  logic [DLW-1:0]    ti [NTERMS];
  logic [DLW-1:0]    tj [NTERMS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      ten    <= '0;
      for (int t = 0; t < NTERMS; t++) begin
        ti[t] <= '0;
        tj[t] <= '0;
      end
    end else if (cfg_we && !tbl_sel) begin
      if (reg_sel == '0) bank_q <= cfg_wdata[BW-1:0];
      for (int t = 0; t < NTERMS; t++) begin
        if (reg_sel == (CAW-1)'(t + 1)) begin
          ten[t] <= cfg_wdata[0];
          ti[t]  <= cfg_wdata[DLW:1];
          tj[t]  <= cfg_wdata[2*DLW:DLW+1];
        end
      end
    end
  end

  logic [2*CW-1:0] lut [TBL];
  wire  [LAW-1:0]  wa = LAW'((int'(w_bank) * NTERMS + int'(w_term)) * TD + int'(w_idx));

  always_ff @(posedge clk)
    if (cfg_we && tbl_sel && term_ok) lut[wa] <= cfg_wdata;

  // stage 1: gain lookup and multiplicand select
  logic [LAW-1:0]       ra   [NTERMS];
  logic signed [CW-1:0] g_i  [NTERMS];
  logic signed [CW-1:0] g_q  [NTERMS];
  logic signed [DW-1:0] xs_i [NTERMS];
  logic signed [DW-1:0] xs_q [NTERMS];
  logic [NTERMS-1:0]    e1;

  always_comb
    for (int t = 0; t < NTERMS; t++)
      ra[t] = LAW'((int'(bank_q) * NTERMS + t) * TD + int'(hmag[ti[t]]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1 <= '0;
      for (int t = 0; t < NTERMS; t++) begin
        g_i[t]  <= '0;
        g_q[t]  <= '0;
        xs_i[t] <= '0;
        xs_q[t] <= '0;
      end
    end else begin
      e1 <= ten;
      for (int t = 0; t < NTERMS; t++) begin
        g_i[t]  <= lut[ra[t]][2*CW-1:CW];
        g_q[t]  <= lut[ra[t]][CW-1:0];
        xs_i[t] <= hx_i[tj[t]];
        xs_q[t] <= hx_q[tj[t]];
      end
    end
  end

  // stage 2: complex products
  logic signed [PW:0] p_i [NTERMS];
  logic signed [PW:0] p_q [NTERMS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NTERMS; t++) begin
        p_i[t] <= '0;
        p_q[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NTERMS; t++) begin
        p_i[t] <= e1[t] ? ((PW+1)'(g_i[t]) * (PW+1)'(xs_i[t]) - (PW+1)'(g_q[t]) * (PW+1)'(xs_q[t])) : '0;
        p_q[t] <= e1[t] ? ((PW+1)'(g_i[t]) * (PW+1)'(xs_q[t]) + (PW+1)'(g_q[t]) * (PW+1)'(xs_i[t])) : '0;
      end
    end
  end

  // stage 3: sum, round, saturate
  logic signed [AW-1:0] s_i, s_q;
  wire  signed [AW-1:0] half = $signed(AW'(1) << (FRAC - 1));

  always_comb begin
    s_i = '0;
    s_q = '0;
    for (int t = 0; t < NTERMS; t++) begin
      s_i = s_i + AW'(p_i[t]);
      s_q = s_q + AW'(p_q[t]);
    end
  end

  wire signed [AW-1:0] r_i = (s_i + half) >>> FRAC;
  wire signed [AW-1:0] r_q = (s_q + half) >>> FRAC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_i <= '0;
      out_q <= '0;
    end else begin
      out_i <= clip(r_i);
      out_q <= clip(r_q);
    end
  end
endmodule

module gmp_lut_predist_chk #(
  parameter int DW     = 16,
  parameter int NTERMS = 2,
  parameter int BW     = 2,
  parameter int CAW    = 12
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 cfg_we,
  input logic [CAW-1:0]       cfg_addr,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q,
  input logic [BW-1:0]        bank_q,
  input logic [NTERMS-1:0]    ten
);
  logic [3:0] quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) quiet <= '0;
    else if (in_i == '0 && in_q == '0) quiet <= (quiet == 4'hF) ? quiet : quiet + 4'd1;
    else quiet <= '0;
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> (out_i == '0 && out_q == '0));

  p_idle_terms_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ten, 3) == '0) |-> (out_i == '0 && out_q == '0));

  p_quiet_history_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet >= 4'd11) |-> (out_i == '0 && out_q == '0));

  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == '0) |=> $stable(bank_q));

  p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(ten));
endmodule

bind gmp_lut_predist gmp_lut_predist_chk #(
  .DW(DW), .NTERMS(NTERMS), .BW(BW), .CAW(CAW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_i(in_i), .in_q(in_q),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .out_i(out_i), .out_q(out_q),
  .bank_q(bank_q), .ten(ten)
);

// File: tb/gmp_lut_predist_test.sv
module gmp_lut_predist_test;
  localparam int NT  = 3;
  localparam int CAW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic cfg_we = 1'b0;
  logic [CAW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic signed [15:0] out_i, out_q;

  gmp_lut_predist #(.NTERMS(NT)) uut (
    .clk(clk), .rst_n(rst_n), .in_i(in_i), .in_q(in_q),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_i(out_i), .out_q(out_q)
  );

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [31:0] lut_m [4][NT][256];
  int tap_i [NT], tap_j [NT];
  bit ten_m [NT];
  int bank_m = 0;
  int h_i [8], h_q [8];
  int seed = 7;

  typedef struct { int ei; int eq; string tag; } exp_t;
  exp_t sb [$];
  logic drv = 1'b0;
  logic [3:0] vp = '0;

  always @(posedge clk) vp <= {vp[2:0], drv};

  always @(negedge clk) begin
    if (vp[3]) begin
      exp_t e;
      n_tests++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R3: output (%0d,%0d) with nothing expected", out_i, out_q);
      end else begin
        e = sb.pop_front();
        if (int'(out_i) != e.ei || int'(out_q) != e.eq) begin
          n_fail++;
          $display("FAIL %s: out=(%0d,%0d) expected (%0d,%0d)", e.tag, out_i, out_q, e.ei, e.eq);
        end
      end
    end
  end

  function automatic int env_m(int a, int b);
    int ua = (a < 0) ? -a : a;
    int ub = (b < 0) ? -b : b;
    int hi, lo, ix;
    if (ua > 32767) ua = 32767;
    if (ub > 32767) ub = 32767;
    hi = (ua > ub) ? ua : ub;
    lo = (ua > ub) ? ub : ua;
    ix = (hi + lo / 2) / 128;
    return (ix > 255) ? 255 : ix;
  endfunction

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic logic [31:0] gain(int mode, int ix);
    int gi, gq;
    case (mode)
      0: begin gi = 16384; gq = 0; end
      1: begin gi = ix * 64; gq = 0; end
      2: begin gi = 32767; gq = 0; end
      3: begin gi = 8000 + ix * 3; gq = -5000 + ix * 7; end
      4: begin gi = -20000; gq = 20000; end
      default: begin gi = 1; gq = 0; end
    endcase
    return {gi[15:0], gq[15:0]};
  endfunction

  function automatic logic [CAW-1:0] tbl_a(int b, int t, int ix);
    return {1'b1, b[1:0], t[1:0], ix[7:0]};
  endfunction

  function automatic logic [CAW-1:0] reg_a(int k);
    return {1'b0, k[11:0]};
  endfunction

  function automatic logic [31:0] ctl_d(bit en, int ti, int tj);
    return {25'd0, tj[2:0], ti[2:0], en};
  endfunction

  function automatic int rnd16();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[30:15]));
  endfunction

  task automatic model_write(logic [CAW-1:0] a, logic [31:0] d);
    if (a[CAW-1]) begin
      if (int'(a[9:8]) < NT) lut_m[a[11:10]][a[9:8]][a[7:0]] = d;
    end else if (a[11:0] == 0) begin
      bank_m = int'(d[1:0]);
    end else if (int'(a[11:0]) <= NT) begin
      ten_m[int'(a[11:0]) - 1] = d[0];
      tap_i[int'(a[11:0]) - 1] = int'(d[3:1]);
      tap_j[int'(a[11:0]) - 1] = int'(d[6:4]);
    end
  endtask

  task automatic step(bit we, logic [CAW-1:0] a, logic [31:0] d, int si, int sq, string tag);
    longint ai = 0, aq = 0;
    exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    in_i = si[15:0]; in_q = sq[15:0];
    if (we) model_write(a, d);
    for (int k = 7; k > 0; k--) begin h_i[k] = h_i[k-1]; h_q[k] = h_q[k-1]; end
    h_i[0] = int'($signed(si[15:0]));
    h_q[0] = int'($signed(sq[15:0]));
    for (int t = 0; t < NT; t++) begin
      if (ten_m[t]) begin
        logic [31:0] w = lut_m[bank_m][t][env_m(h_i[tap_i[t]], h_q[tap_i[t]])];
        longint gi = longint'($signed(w[31:16]));
        longint gq = longint'($signed(w[15:0]));
        ai += gi * h_i[tap_j[t]] - gq * h_q[tap_j[t]];
        aq += gi * h_q[tap_j[t]] + gq * h_i[tap_j[t]];
      end
    end
    e.ei = sat16((ai + 8192) >>> 14);
    e.eq = sat16((aq + 8192) >>> 14);
    e.tag = tag;
    sb.push_back(e);
    drv = 1'b1;
  endtask

  task automatic fill(int b, int t, int mode, string tag);
    for (int ix = 0; ix < 256; ix++) step(1'b1, tbl_a(b, t, ix), gain(mode, ix), 0, 0, tag);
  endtask

  task automatic setreg(int k, logic [31:0] d, string tag);
    step(1'b1, reg_a(k), d, 0, 0, tag);
  endtask

  task automatic burst(int n, string tag);
    for (int k = 0; k < n; k++) step(1'b0, '0, '0, rnd16(), rnd16(), tag);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL R3: watchdog expired, %0d results outstanding", sb.size());
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin ten_m[t] = 0; tap_i[t] = 0; tap_j[t] = 0; end
    for (int k = 0; k < 8; k++) begin h_i[k] = 0; h_q[k] = 0; end
    for (int b = 0; b < 4; b++) for (int t = 0; t < NT; t++) for (int ix = 0; ix < 256; ix++) lut_m[b][t][ix] = '0;

    repeat (5) @(negedge clk);
    n_tests++;
    if (out_i != 0 || out_q != 0) begin
      n_fail++;
      $display("FAIL R1: in reset out=(%0d,%0d) expected (0,0)", out_i, out_q);
    end
    in_i = 16'sd12000; in_q = -16'sd9000;
    @(negedge clk); rst_n = 1'b1; in_i = '0; in_q = '0;
    @(negedge clk);
    n_tests++;
    if (out_i != 0 || out_q != 0) begin
      n_fail++;
      $display("FAIL R1: after reset out=(%0d,%0d) expected (0,0)", out_i, out_q);
    end

    // R1: all terms disabled while tables are cleared; R11 addressing
    for (int b = 0; b < 4; b++) for (int t = 0; t < NT; t++) fill(b, t, 9, "R11");
    for (int b = 0; b < 4; b++) for (int t = 0; t < NT; t++)
      for (int ix = 0; ix < 256; ix++) step(1'b1, tbl_a(b, t, ix), '0, 0, 0, "R11");
    burst(12, "R1");

    // R2 identity, R3 latency via impulse
    fill(0, 0, 0, "R2");
    setreg(1, ctl_d(1, 0, 0), "R2");
    step(1'b0, '0, '0, 32767, -32768, "R2");
    step(1'b0, '0, '0, -32768, 32767, "R2");
    step(1'b0, '0, '0, 1, -1, "R2");
    burst(40, "R2");
    step(1'b0, '0, '0, 23456, -7777, "R3");
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0, 0, 0, "R3");

    // R5 envelope index via ramp table, multiplicand one sample back
    fill(0, 1, 1, "R5");
    setreg(1, ctl_d(0, 0, 0), "R5");
    setreg(2, ctl_d(1, 0, 1), "R5");
    step(1'b0, '0, '0, 16384, 0, "R5");
    step(1'b0, '0, '0, -32768, -32768, "R5");
    step(1'b0, '0, '0, 16384, 0, "R5");
    step(1'b0, '0, '0, 100, 50, "R5");
    step(1'b0, '0, '0, 16384, 0, "R5");
    step(1'b0, '0, '0, 127, 2, "R5");
    step(1'b0, '0, '0, 128, 0, "R5");
    step(1'b0, '0, '0, 20000, -30000, "R5");
    burst(30, "R5");

    // R4 independent taps across two terms
    setreg(1, ctl_d(1, 5, 2), "R4");
    setreg(2, ctl_d(1, 7, 0), "R4");
    burst(40, "R4");

    // R6 disabled term with large gains
    fill(0, 2, 4, "R6");
    setreg(3, ctl_d(0, 3, 3), "R6");
    burst(30, "R6");
    setreg(1, ctl_d(0, 0, 0), "R6");
    setreg(2, ctl_d(0, 0, 0), "R6");
    burst(15, "R6");

    // R9 complex gains
    fill(1, 0, 3, "R9");
    fill(1, 1, 0, "R9");
    setreg(0, 32'd1, "R9");
    setreg(1, ctl_d(1, 0, 0), "R9");
    burst(40, "R9");

    // R7 bank switching, R10 write lands with the sample in the same cycle
    setreg(2, ctl_d(1, 1, 4), "R7");
    for (int k = 0; k < 8; k++) begin
      step(1'b1, reg_a(0), 32'(k % 3), rnd16(), rnd16(), "R10");
      burst(3, "R7");
    end
    step(1'b1, reg_a(1), ctl_d(0, 0, 0), 30000, 30000, "R10");
    step(1'b1, reg_a(1), ctl_d(1, 0, 0), 30000, -30000, "R10");

    // R8 saturation and rounding
    fill(3, 0, 2, "R8");
    fill(3, 1, 2, "R8");
    fill(3, 2, 2, "R8");
    setreg(0, 32'd3, "R8");
    setreg(1, ctl_d(1, 0, 0), "R8");
    setreg(2, ctl_d(1, 0, 0), "R8");
    setreg(3, ctl_d(1, 0, 0), "R8");
    step(1'b0, '0, '0, 32767, -32768, "R8");
    step(1'b0, '0, '0, -20000, 20000, "R8");
    step(1'b0, '0, '0, 5000, -5000, "R8");
    burst(20, "R8");
    fill(2, 0, 5, "R8");
    setreg(0, 32'd2, "R8");
    setreg(2, ctl_d(0, 0, 0), "R8");
    setreg(3, ctl_d(0, 0, 0), "R8");
    step(1'b0, '0, '0, 8192, 8191, "R8");
    step(1'b0, '0, '0, -8192, -8193, "R8");
    step(1'b0, '0, '0, 24576, -24577, "R8");
    for (int k = 0; k < 4; k++) step(1'b0, '0, '0, 0, 0, "R8");

    @(negedge clk);
    drv = 1'b0;
    cfg_we = 1'b0;
    repeat (8) @(negedge clk);
    if (sb.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL R3: %0d results never appeared, expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule